// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Synthesizer

This block is a two-wire serial slave holding six byte-wide configuration registers of a clock synthesizer. Their contents drive parallel control outputs: a frequency code with a selector bit that chooses between the code and the latched strap pins, spread-spectrum enable and spread direction, a global output tri-state bit, and per-output enable bits. The bus lines are oversampled by a fast system clock. Both lines pass through a synchronizer and a two-sample glitch filter. Start and stop conditions are taken from SDA edges while SCL is high.

A host writes with the write address. It then sends a command code and a byte count, and the slave acknowledges both and throws them away. The data that follows lands in register 0, 1, 2 and so on, in that order. A stop after any whole byte leaves the remaining registers as they were. A host reads with the read address. The slave first returns a count of 6 and then registers 0 through 5, continuing while the host acknowledges. The slave never holds SCL low.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). The address is the upper seven bits of the byte and the R/W flag is bit 0. Any other address byte is not acknowledged and changes no register.
- R2: In a write, the first two bytes after the address are a command code and a byte count. The slave acknowledges both and stores neither.
- R3: Write data bytes go to registers 0, 1, 2 and onward in order, and each is acknowledged. A stop after k data bytes leaves registers k and above unchanged.
- R4: In a read, the slave returns the byte count 0x06 first and then registers 0 to 5 in order, most significant bit first.
- R5: After reset the register values are 0x00, 0xD7, 0xFF, 0x73, 0x71 and 0x00 for registers 0 to 5. Register 0 = 0 selects the strap pins as the frequency source.
- R6: Register 0 drives the control outputs by bit position: bits 7:4 give freq_code, bit 3 gives freq_from_reg (0 = strap pins, 1 = code), bit 2 gives spread_down (0 = center ±0.25 %, 1 = down 0 to -0.5 %), bit 1 gives spread_on, and bit 0 gives out_tristate.
- R7: Reserved bits always read back as 0 and never reach an output. These are register 1 bits 5 and 3, register 3 bits 7, 3 and 2, register 4 bits 7, 3, 2 and 1, and all of register 5.
- R8: Write data bytes beyond the sixth are acknowledged and ignored.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A one-system-clock pulse on SDA while SCL is high is neither a start nor a stop.
- R11: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more.
- R12: gate_en carries registers 4, 3, 2 and 1 in bits 31:24, 23:16, 15:8 and 7:0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_o | output | 1 | Data value driven onto the bus (always 0, open-drain) |
| sda_oe | output | 1 | High when the slave pulls SDA low |
| freq_code | output | 4 | Frequency code, register 0 bits 7:4 |
| freq_from_reg | output | 1 | Frequency source select, register 0 bit 3 |
| spread_down | output | 1 | Spread direction, register 0 bit 2 |
| spread_on | output | 1 | Spread-spectrum enable, register 0 bit 1 |
| out_tristate | output | 1 | Tri-state all clock outputs, register 0 bit 0 |
| gate_en | output | 32 | Output enables, registers 4..1 with reserved bits zero |

## Verification
The bench checks four cases that have clear failure signatures:

- **Discarded header bytes.** If the command code and byte count were not dropped, register 0 would read back 0xAA instead of the first data byte.
- **Partial write.** If a stop after two data bytes did not end the write, the third register would no longer hold its old value.
- **Write overrun.** If writes past the sixth byte were mishandled, an index wrap would overwrite register 0, or the extra bytes would go unacknowledged.
- **Host NACK during a read.** If the slave ignored the NACK, it would pull SDA low for the next byte's leading zero.

A one-cycle SDA dip during a data bit checks the filter: without it, the dip is taken as a restart and the write aborts. Reading back after writing all-ones shows whether reserved bits were stored.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [47:0] WMASK    = {8'h00, 8'h71, 8'h73, 8'hFF, 8'hD7, 8'hFF},
  parameter logic [47:0] DEFAULTS = {8'h00, 8'h71, 8'h73, 8'hFF, 8'hD7, 8'h00}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe,
  output logic [3:0]  freq_code,
  output logic        freq_from_reg,
  output logic        spread_down,
  output logic        spread_on,
  output logic        out_tristate,
  output logic [31:0] gate_en
);
  localparam int NREG = 6;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [2:0] scl_s, sda_s;
  logic       scl_f, sda_f, scl_p, sda_p;
  st_t        st;
  logic [7:0] rf [NREG];
  logic [7:0] sh, tx_next;
  logic [3:0] bitcnt, idx;
  logic       addr_ph, rw, drv, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      if (scl_s[2] == scl_s[1]) scl_f <= scl_s[1];
      if (sda_s[2] == sda_s[1]) sda_f <= sda_s[1];
      scl_p <= scl_f;
      sda_p <= sda_f;
    end

  wire start_c = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c  = scl_f & scl_p & ~sda_p & sda_f;
  wire rise    = scl_f & ~scl_p;
  wire fall    = ~scl_f & scl_p;

  always_comb begin
    tx_next = 8'h00;
    if (idx == 4'd0) tx_next = 8'(NREG);
    else if (idx <= 4'(NREG)) tx_next = rf[3'(idx - 4'd1)];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; bitcnt <= '0; idx <= '0;
      addr_ph <= 1'b0; rw <= 1'b0; drv <= 1'b0; mack <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= DEFAULTS[8*i +: 8];
    end else if (start_c) begin
      st <= S_RX; addr_ph <= 1'b1; bitcnt <= '0; idx <= '0; drv <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; drv <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (rise) begin
            sh <= {sh[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (addr_ph) begin
              if (sh[7:1] == DEV_ADDR) begin
                addr_ph <= 1'b0; rw <= sh[0]; drv <= 1'b1; st <= S_RACK;
              end else st <= S_IDLE;
            end else begin
              drv <= 1'b1; st <= S_RACK;
              for (int i = 0; i < NREG; i++)
                if (idx == 4'(i + 2)) rf[i] <= sh & WMASK[8*i +: 8];
              if (idx != 4'hF) idx <= idx + 4'd1;
            end
          end
        S_RACK:
          if (fall) begin
            if (rw) begin
              sh <= tx_next; drv <= ~tx_next[7]; bitcnt <= '0; st <= S_TX;
              if (idx != 4'hF) idx <= idx + 4'd1;
            end else begin
              drv <= 1'b0; st <= S_RX;
            end
          end
        S_TX:
          if (fall) begin
            if (bitcnt == 4'd7) begin
              drv <= 1'b0; st <= S_TACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; drv <= ~sh[6]; bitcnt <= bitcnt + 4'd1;
            end
          end
        S_TACK:
          if (rise) mack <= ~sda_f;
          else if (fall) begin
            if (mack) begin
              sh <= tx_next; drv <= ~tx_next[7]; bitcnt <= '0; st <= S_TX;
              if (idx != 4'hF) idx <= idx + 4'd1;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end

  assign sda_o  = 1'b0;
  assign sda_oe = drv;
  assign {freq_code, freq_from_reg, spread_down, spread_on, out_tristate} = rf[0];
  assign gate_en = {rf[4], rf[3], rf[2], rf[1]};
endmodule

module cfg_i2c_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [31:0] gate_en
);
  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);
  // R5
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> gate_en == 32'h7173FFD7);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & 32'h8E8C0028) == 32'h0);
  // R3
  write_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_en) |-> !scl_i);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .gate_en(gate_en)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_o, sda_oe, freq_from_reg, spread_down, spread_on, out_tristate;
  logic [3:0] freq_code;
  logic [31:0] gate_en;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [6];
  int nchk = 0, nfail = 0, r9_viol = 0;
  logic prev_oe = 1'b0;

  wire sda_line = m_sda & ~(sda_oe & ~sda_o);

  always #10 clk = ~clk;

  cfg_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .freq_code(freq_code),
    .freq_from_reg(freq_from_reg), .spread_down(spread_down),
    .spread_on(spread_on), .out_tristate(out_tristate), .gate_en(gate_en)
  );

  always @(posedge clk) begin
    if (rst_n && sda_oe != prev_oe && m_scl) r9_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(Q);
      if (glitch && i == 6) begin
        m_sda = 1'b0; @(negedge clk); m_sda = b[i]; wq(Q-1);
      end else wq(Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = (sda_line == 1'b0);
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line;
      wq(Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = ~ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic do_write(input int n, input logic glitch);
    logic a;
    i2c_start;
    send_byte(8'hD2, 1'b0, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'hAA, 1'b0, a); chk(a, "R2 command ack", a, 1);
    send_byte(8'h06, 1'b0, a); chk(a, "R2 count ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], glitch && k == 0, a);
      chk(a, k < 6 ? "R3 data ack" : "R8 extra data ack", a, 1);
    end
    i2c_stop;
  endtask

  task automatic do_read(input int n);
    logic a;
    logic [7:0] c;
    i2c_start;
    send_byte(8'hD3, 1'b0, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, c); chk(c == 8'h06, "R4 byte count", c, 8'h06);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
  endtask

  task automatic check_regs(input logic [47:0] exp, input string tag);
    do_read(6);
    i2c_stop;
    for (int k = 0; k < 6; k++)
      chk(rbuf[k] == exp[8*k +: 8], tag, rbuf[k], exp[8*k +: 8]);
  endtask

  task automatic t_reset;
    chk(gate_en == 32'h7173FFD7, "R5 reset gate_en", gate_en, 32'h7173FFD7);
    chk({freq_code, freq_from_reg, spread_down, spread_on, out_tristate} == 8'h00,
        "R5 reset register 0", {freq_code, freq_from_reg, spread_down, spread_on, out_tristate}, 0);
    check_regs({8'h00, 8'h71, 8'h73, 8'hFF, 8'hD7, 8'h00}, "R5 R4 reset readback");
  endtask

  task automatic t_full_write;
    wbuf[0] = 8'h5B; wbuf[1] = 8'hFF; wbuf[2] = 8'h00;
    wbuf[3] = 8'hFF; wbuf[4] = 8'hFF; wbuf[5] = 8'hFF;
    do_write(6, 1'b0);
    chk(freq_code == 4'h5, "R6 freq_code", freq_code, 5);
    chk(freq_from_reg == 1'b1, "R6 freq_from_reg", freq_from_reg, 1);
    chk(spread_down == 1'b0, "R6 spread_down", spread_down, 0);
    chk(spread_on == 1'b1, "R6 spread_on", spread_on, 1);
    chk(out_tristate == 1'b1, "R6 out_tristate", out_tristate, 1);
    chk(gate_en == 32'h717300D7, "R12 R7 gate_en map", gate_en, 32'h717300D7);
    check_regs({8'h00, 8'h71, 8'h73, 8'h00, 8'hD7, 8'h5B}, "R7 R2 readback after full write");
  endtask

  task automatic t_partial;
    wbuf[0] = 8'hA6; wbuf[1] = 8'h12;
    do_write(2, 1'b0);
    chk({freq_code, freq_from_reg, spread_down, spread_on, out_tristate} == 8'hA6,
        "R3 partial register 0", {freq_code, freq_from_reg, spread_down, spread_on, out_tristate}, 8'hA6);
    chk(gate_en == 32'h71730012, "R3 partial leaves rest", gate_en, 32'h71730012);
  endtask

  task automatic t_bad_addr;
    logic a;
    i2c_start;
    send_byte(8'hD0, 1'b0, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'hFF, 1'b0, a); chk(!a, "R1 no ack after foreign address", a, 0);
    i2c_stop;
    chk(gate_en == 32'h71730012, "R1 foreign write no effect", gate_en, 32'h71730012);
  endtask

  task automatic t_overrun;
    wbuf[0] = 8'h31; wbuf[1] = 8'hC4; wbuf[2] = 8'h3C; wbuf[3] = 8'h0F;
    wbuf[4] = 8'hF0; wbuf[5] = 8'hEE; wbuf[6] = 8'h99; wbuf[7] = 8'h77;
    do_write(8, 1'b0);
    chk(gate_en == 32'h70033CC4, "R8 gate_en after overrun", gate_en, 32'h70033CC4);
    check_regs({8'h00, 8'h70, 8'h03, 8'h3C, 8'hC4, 8'h31}, "R8 readback after overrun");
  endtask

  task automatic t_read_nack;
    do_read(2);
    chk(rbuf[1] == 8'hC4, "R4 second byte", rbuf[1], 8'hC4);
    wq(2*Q);
    chk(sda_oe == 1'b0, "R11 released after nack", sda_oe, 0);
    i2c_stop;
    chk(sda_oe == 1'b0, "R11 idle after stop", sda_oe, 0);
  endtask

  task automatic t_glitch;
    wbuf[0] = 8'h5B;
    do_write(1, 1'b1);
    chk({freq_code, freq_from_reg, spread_down, spread_on, out_tristate} == 8'h5B,
        "R10 write survives sda glitch", {freq_code, freq_from_reg, spread_down, spread_on, out_tristate}, 8'h5B);
    chk(gate_en == 32'h70033CC4, "R10 other registers intact", gate_en, 32'h70033CC4);
  endtask

  logic done = 1'b0;
  initial begin
    wq(5); rst_n = 1'b1; wq(5);
    t_reset;
    t_full_write;
    t_partial;
    t_bad_addr;
    t_overrun;
    t_read_nack;
    t_glitch;
    chk(r9_viol == 0, "R9 sda drive changes with scl high", r9_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule